// File: doc/BRIEF.md
# RS485 Driver-Enable Sequencer

This block drives the enable pin of an RS485 line transceiver around the frames a UART transmitter sends. When the transmitter reports data waiting, the block turns the driver on, waits a programmable number of oversampling ticks (one tick is 1/16 of a bit time), and only then grants the transmitter permission to send its start bit. After the final stop bit of the last frame, it keeps the driver on for a second programmable number of ticks. It then releases the driver and raises the transmission-complete flag on the same clock edge.

Permission works like a ready signal in a valid/ready pair. `tx_pend` is the valid side. The transmitter raises it while a character is waiting and must not start a frame until `start_ok` is high. The transmitter reports each frame it starts with `frame_start` and each finished stop bit with `last_stop_done`. If more data is pending when a frame ends, the driver stays on and permission stays granted, so no new lead delay is inserted. If data arrives during the trail delay, the trail is abandoned and the next frame may start at once.

With the mode disabled, the pin sits at its inactive level and permission is always granted. In that state the completion flag follows the end of the stop bit directly. The pin's active level is set by a polarity input.

Top module: `rs485_de_timer`

## Requirements
- R1: After reset, with the mode enabled, `de_pin` is at its inactive level, `start_ok` is 0 and `tc` is 1.
- R2: `de_pin` equals `de_pol` while the driver is enabled and equals the inverse of `de_pol` while it is released (`de_pol`=1 means active high).
- R3: A pending request seen while idle enables the driver on the next edge. `start_ok` rises after exactly `lead_dly` further ticks. A value of 0 grants `start_ok` on that same first edge.
- R4: Once the last stop bit has finished with nothing pending, `tc` rises after exactly `trail_dly` ticks. A value of 0 raises it on the edge that samples `last_stop_done`.
- R5: The driver is released on the same edge on which `tc` rises, and `tc` is never 1 while the driver is enabled in RS485 mode.
- R6: If `tx_pend` is high when a frame's stop bit ends, the driver stays enabled and `start_ok` stays 1 with no lead delay.
- R7: A `tx_pend` seen during the trail delay cancels it. `start_ok` is 1 on the next edge, the driver never drops, and `tc` stays 0.
- R8: `tc` is 0 from the edge after any cycle with `tx_pend` high.
- R9: With `mode_en` low, `de_pin` is inactive and `start_ok` is 1. `tc` rises on the edge after `last_stop_done` when nothing is pending.
- R10: Between `frame_start` and `last_stop_done` the driver stays enabled even when `tx_pend` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per oversampling tick |
| mode_en | input | 1 | RS485 driver-enable mode on |
| de_pol | input | 1 | Active level of `de_pin` |
| lead_dly | input | DLY_W | Ticks between driver enable and start permission |
| trail_dly | input | DLY_W | Ticks between last stop bit and completion |
| tx_pend | input | 1 | Character waiting to be sent (valid) |
| frame_start | input | 1 | Pulse: transmitter began a start bit |
| last_stop_done | input | 1 | Pulse: transmitter finished a stop bit |
| de_pin | output | 1 | Transceiver driver enable, polarity applied |
| start_ok | output | 1 | Permission to begin a frame (ready) |
| tc | output | 1 | Transmission complete flag |

## Verification
The bench measures both delays in ticks at values of zero and non-zero. A counter that is off by one, or that also counts the tick on the loading edge, shows up as a wrong count. It checks that the driver drop and the completion flag land on one edge; a design that releases one cycle early or late is reported. Back-to-back frames and a request arriving mid-trail are exercised. A design that re-runs the lead delay, or that lets the driver glitch off, loses permission or flashes the flag. Inverted polarity and the disabled mode are also checked at the pin.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_XFER  = 2'd2,
    ST_TRAIL = 2'd3
  } de_state_e;
endpackage

// File: rtl/rs485_dly_cnt.sv
module rs485_dly_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/rs485_de_fsm.sv
module rs485_de_fsm
  import rs485_de_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic tx_pend,
  input  logic frame_start,
  input  logic last_stop_done,
  input  logic lead_zero,
  input  logic trail_zero,
  input  logic lead_exp,
  input  logic trail_exp,
  output logic ld_lead,
  output logic ld_trail,
  output logic run_lead,
  output logic run_trail,
  output logic de_act,
  output logic start_ok,
  output logic tc
);
  de_state_e st_q, st_d;
  logic busy_q, busy_d;
  logic tc_d, set_tc;

  always_comb begin
    busy_d   = frame_start ? 1'b1 : (last_stop_done ? 1'b0 : busy_q);
    st_d     = st_q;
    ld_lead  = 1'b0;
    ld_trail = 1'b0;
    set_tc   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tx_pend) begin
          if (lead_zero) begin
            st_d = ST_XFER;
          end else begin
            st_d    = ST_LEAD;
            ld_lead = 1'b1;
          end
        end
      end
      ST_LEAD: begin
        if (lead_exp) st_d = ST_XFER;
      end
      ST_XFER: begin
        if (!busy_d && !tx_pend) begin
          if (trail_zero) begin
            st_d   = ST_IDLE;
            set_tc = 1'b1;
          end else begin
            st_d     = ST_TRAIL;
            ld_trail = 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (tx_pend) begin
          st_d = ST_XFER;
        end else if (trail_exp) begin
          st_d   = ST_IDLE;
          set_tc = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!mode_en) begin
      st_d     = ST_IDLE;
      ld_lead  = 1'b0;
      ld_trail = 1'b0;
      set_tc   = last_stop_done && !tx_pend;
    end
    tc_d = tx_pend ? 1'b0 : (set_tc ? 1'b1 : tc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      busy_q <= 1'b0;
      tc     <= 1'b1;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
      tc     <= tc_d;
    end
  end

  assign run_lead  = (st_q == ST_LEAD);
  assign run_trail = (st_q == ST_TRAIL);
  assign de_act    = mode_en && (st_q != ST_IDLE);
  assign start_ok  = mode_en ? (st_q == ST_XFER) : 1'b1;
endmodule

// File: rtl/rs485_de_drive.sv
module rs485_de_drive (
  input  logic de_act,
  input  logic de_pol,
  output logic de_pin
);
  assign de_pin = de_pol ? de_act : ~de_act;
endmodule

// File: rtl/rs485_de_timer.sv
module rs485_de_timer #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mode_en,
  input  logic             de_pol,
  input  logic [DLY_W-1:0] lead_dly,
  input  logic [DLY_W-1:0] trail_dly,
  input  logic             tx_pend,
  input  logic             frame_start,
  input  logic             last_stop_done,
  output logic             de_pin,
  output logic             start_ok,
  output logic             tc
);
  localparam int NCNT = 2;

  logic [NCNT-1:0] ld, run, expire;
  logic [DLY_W-1:0] dly [NCNT];
  logic de_act;

  assign dly[0] = lead_dly;
  assign dly[1] = trail_dly;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    rs485_dly_cnt #(.W(DLY_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld[i]),
      .load_val (dly[i]),
      .run      (run[i]),
      .tick     (tick),
      .expire   (expire[i])
    );
  end

  rs485_de_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_en        (mode_en),
    .tx_pend        (tx_pend),
    .frame_start    (frame_start),
    .last_stop_done (last_stop_done),
    .lead_zero      (lead_dly == '0),
    .trail_zero     (trail_dly == '0),
    .lead_exp       (expire[0]),
    .trail_exp      (expire[1]),
    .ld_lead        (ld[0]),
    .ld_trail       (ld[1]),
    .run_lead       (run[0]),
    .run_trail      (run[1]),
    .de_act         (de_act),
    .start_ok       (start_ok),
    .tc             (tc)
  );

  rs485_de_drive u_drive (
    .de_act (de_act),
    .de_pol (de_pol),
    .de_pin (de_pin)
  );
endmodule

// File: rtl/rs485_de_chk.sv
module rs485_de_chk #(
  parameter int DLY_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             mode_en,
  input logic             de_pol,
  input logic [DLY_W-1:0] lead_dly,
  input logic [DLY_W-1:0] trail_dly,
  input logic             tx_pend,
  input logic             frame_start,
  input logic             last_stop_done,
  input logic             de_pin,
  input logic             start_ok,
  input logic             tc
);
  AST_OFF_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> (de_pin == !de_pol && start_ok)); // R9
  AST_PERMIT_NEEDS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && start_ok) |-> (de_pin == de_pol)); // R2
  AST_TC_EXCLUDES_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |-> !(tc && de_pin == de_pol)); // R5
  AST_TC_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && $rose(tc)) |-> (de_pin != de_pol)); // R5
  AST_PEND_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pend |=> !tc); // R8
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && start_ok && tx_pend && last_stop_done) |=> (mode_en |-> start_ok)); // R6
endmodule

bind rs485_de_timer rs485_de_chk #(.DLY_W(DLY_W)) u_chk (.*);

// File: tb/rs485_de_timer_test.sv
module rs485_de_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic mode_en = 1'b1;
  logic de_pol = 1'b1;
  logic [4:0] lead_dly = '0;
  logic [4:0] trail_dly = '0;
  logic tx_pend = 1'b0;
  logic frame_start = 1'b0;
  logic last_stop_done = 1'b0;
  logic de_pin, start_ok, tc;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rs485_de_timer #(.DLY_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_en(mode_en), .de_pol(de_pol),
    .lead_dly(lead_dly), .trail_dly(trail_dly), .tx_pend(tx_pend),
    .frame_start(frame_start), .last_stop_done(last_stop_done),
    .de_pin(de_pin), .start_ok(start_ok), .tc(tc)
  );

  initial begin : tick_gen
    int ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph = (ph + 1) % 4;
      tick = (ph == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int drv_on();
    return int'(de_pin == de_pol);
  endfunction

  // Raise tx_pend; count ticks until start_ok; check driver stays on.
  task automatic lead_phase(input int n, input string req);
    int cnt = 0;
    int de_bad = 0;
    @(negedge clk);
    lead_dly = 5'(n);
    tx_pend = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 500; i++) begin
      if (drv_on() == 0) de_bad++;
      if (start_ok) break;
      if (tick) cnt++;
      @(negedge clk);
    end
    chk({req, " lead ticks"}, cnt, n);
    chk("R2 driver on during lead", de_bad, 0);
  endtask

  task automatic start_frame(input bit more);
    @(negedge clk);
    frame_start = 1'b1;
    tx_pend = more;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 driver held in frame", drv_on(), 1);
  endtask

  task automatic trail_phase(input int n, input string req);
    int cnt = 0;
    int de_bad = 0;
    @(negedge clk);
    trail_dly = 5'(n);
    last_stop_done = 1'b1;
    @(negedge clk);
    last_stop_done = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (tc) break;
      if (drv_on() == 0) de_bad++;
      if (tick) cnt++;
      @(negedge clk);
    end
    chk({req, " trail ticks"}, cnt, n);
    chk("R5 released with tc", drv_on(), 0);
    chk("R5 no early release", de_bad, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset pin", int'(de_pin), 0);
    chk("R1 reset start_ok", int'(start_ok), 0);
    chk("R1 reset tc", int'(tc), 1);
  endtask

  task automatic t_delays(input int ld, input int tr);
    lead_phase(ld, "R3");
    start_frame(1'b0);
    trail_phase(tr, "R4");
  endtask

  task automatic t_tc_clear();
    @(negedge clk);
    chk("R8 tc before", int'(tc), 1);
    lead_dly = 5'd4;
    tx_pend = 1'b1;
    @(negedge clk);
    chk("R8 tc cleared", int'(tc), 0);
    for (int i = 0; i < 100 && !start_ok; i++) @(negedge clk);
    start_frame(1'b0);
    trail_phase(2, "R4");
  endtask

  task automatic t_back_to_back();
    lead_phase(2, "R3");
    start_frame(1'b1);
    @(negedge clk);
    last_stop_done = 1'b1;
    @(negedge clk);
    last_stop_done = 1'b0;
    chk("R6 start_ok held", int'(start_ok), 1);
    chk("R6 driver held", drv_on(), 1);
    chk("R6 tc low", int'(tc), 0);
    start_frame(1'b0);
    trail_phase(3, "R4");
  endtask

  task automatic t_trail_cancel();
    lead_phase(1, "R3");
    start_frame(1'b0);
    @(negedge clk);
    trail_dly = 5'd8;
    last_stop_done = 1'b1;
    @(negedge clk);
    last_stop_done = 1'b0;
    @(negedge clk);
    chk("R7 in trail", int'(start_ok), 0);
    tx_pend = 1'b1;
    @(negedge clk);
    chk("R7 start_ok back", int'(start_ok), 1);
    chk("R7 driver held", drv_on(), 1);
    chk("R7 tc low", int'(tc), 0);
    start_frame(1'b0);
    trail_phase(8, "R4");
  endtask

  task automatic t_polarity();
    @(negedge clk);
    de_pol = 1'b0;
    #1;
    chk("R2 low-active idle pin", int'(de_pin), 1);
    lead_dly = 5'd1;
    tx_pend = 1'b1;
    @(negedge clk);
    chk("R2 low-active on pin", int'(de_pin), 0);
    for (int i = 0; i < 100 && !start_ok; i++) @(negedge clk);
    start_frame(1'b0);
    trail_phase(1, "R4");
    chk("R2 low-active released pin", int'(de_pin), 1);
    de_pol = 1'b1;
  endtask

  task automatic t_disabled();
    @(negedge clk);
    mode_en = 1'b0;
    tx_pend = 1'b1;
    @(negedge clk);
    chk("R9 pin inactive", int'(de_pin), 0);
    chk("R9 start_ok", int'(start_ok), 1);
    chk("R9 tc cleared", int'(tc), 0);
    frame_start = 1'b1;
    tx_pend = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (3) @(negedge clk);
    last_stop_done = 1'b1;
    @(negedge clk);
    last_stop_done = 1'b0;
    chk("R9 tc direct", int'(tc), 1);
    chk("R9 pin still inactive", int'(de_pin), 0);
    mode_en = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_delays(3, 5);
    t_delays(0, 0);
    t_delays(31, 1);
    t_tc_clear();
    t_back_to_back();
    t_trail_cancel();
    t_polarity();
    t_disabled();
    t_delays(2, 4);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule